// File: doc/BRIEF.md
# Pre-Trigger Capture Spy Buffer

This block writes one sample stream into a ring memory, one sample on every clock, for as long as it is armed. A trigger freezes a window around the trigger instant. The window holds the last PRE samples recorded before the trigger and the POST samples recorded from the trigger onwards, where POST = DEPTH - PRE. With the default parameters the ring is 4096 deep and the split is 64 samples before and 4032 after. Once the window is complete, writing stops and the contents stay put until the block is re-armed.

A trigger comes from one of two sources. The first is an external positive pulse, which passes through a synchronizer and an edge detector. The second is a one-cycle strobe from a control-register write. This trigger has no link to any data-driven trigger elsewhere on the chip. Several instances can share one trigger so that they freeze the same instant. Because the sample width is a parameter, 14-bit converter channels and a 32-bit link monitor use the same block.

A host reads the window through a plain address/data read port. Address 0 returns the oldest pre-trigger sample. The block adds the window start to the host address, so software never sees where the ring happened to stand at the trigger.

The controller has three states:
- RECORD: armed, writing continuously.
- CAPTURE: collecting post-trigger samples.
- FROZEN: window complete, no writes.

It has four transitions:
- RECORD to CAPTURE on a trigger.
- CAPTURE to FROZEN when the last post-trigger sample is written.
- FROZEN to RECORD on a trigger (re-arm).
- Any state to RECORD on reset.

Top module: `spy_capture_buffer`

## Requirements
- R1: After reset the block is in RECORD, with `cap_busy` = 0 and `cap_done` = 0.
- R2: In RECORD and CAPTURE the block writes the value on `smp_data` into the ring at every rising clock edge, at consecutive ring positions.
- R3: A `sw_trig` strobe sampled high at a clock edge while in RECORD starts a capture. The sample written at that same edge is the first post-trigger sample, and it is read back at address PRE.
- R4: `ext_trig_in` passes through a two-flop synchronizer followed by a rising-edge detector. When the input is first sampled high at edge k, the trigger acts at edge k+2. One pulse gives exactly one trigger, however long the input stays high.
- R5: After capture, read address i (0 to DEPTH-1) returns the sample written i-PRE edges after the trigger edge. Addresses 0 to PRE-1 hold the PRE samples that came before the trigger, oldest first.
- R6: `cap_busy` is high after the trigger edge. `cap_done` rises, and `cap_busy` falls, after the edge that lies POST-1 edges past the trigger edge. This is the edge that writes the POST-th post-trigger sample. The two flags are never both high.
- R7: A trigger from either source that arrives during CAPTURE is ignored. It changes neither the window nor the time at which `cap_done` rises.
- R8: In FROZEN the ring is not written. Reads return the frozen window at any later time, with the data one clock after the address.
- R9: A trigger in FROZEN clears `cap_done` and returns to RECORD without capturing. A later trigger captures a fresh window.
- R10: Instances of different sample widths that share the same trigger and stream freeze the same instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | DATA_W | Sample stream, one value per clock |
| ext_trig_in | input | 1 | Asynchronous external trigger pulse, active high |
| sw_trig | input | 1 | One-cycle trigger strobe from a register write |
| rd_addr | input | $clog2(DEPTH) | Window-relative read address, 0 is oldest |
| rd_data | output | DATA_W | Read data, one cycle after `rd_addr` |
| cap_busy | output | 1 | High while post-trigger samples are collected |
| cap_done | output | 1 | High while a complete window is frozen |

## Verification
The bench builds two instances with DEPTH = 32 and PRE = 4, one with DATA_W = 8 and one with DATA_W = 32, fed the same counter stream and the same triggers. The short ring lets each capture be read back in full at every one of its 32 addresses. Triggers are placed at ring phases that step round the memory, so the window start falls at many wrap positions, including windows that straddle the top of the ring. The short post-trigger length also keeps the tests of ignored triggers, held external inputs and re-arming quick.

// File: rtl/spy_pkg.sv
package spy_pkg;
    typedef enum logic [1:0] {
        ST_RECORD  = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_FROZEN  = 2'd2
    } spy_state_t;
endpackage

// File: rtl/spy_trig_sync.sv
module spy_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic sw_in,
    output logic ext_rise,
    output logic trig
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         last_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ext_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[MSB-1:0], ext_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[MSB];
    end

    assign ext_rise = sync_q[MSB] & ~last_q;
    assign trig     = ext_rise | sw_in;
endmodule

// File: rtl/spy_ring_mem.sv
module spy_ring_mem #(
    parameter int DATA_W = 14,
    parameter int DEPTH  = 4096,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata <= store[raddr];
    end
endmodule

// File: rtl/spy_capture_fsm.sv
module spy_capture_fsm
    import spy_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int PRE   = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int POST = DEPTH - PRE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    output logic          we,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] base_ptr,
    output logic          busy,
    output logic          done
);
    localparam logic [AW-1:0] POST_LAST = AW'(POST - 1);
    localparam logic [AW-1:0] PRE_OFS   = AW'(PRE);

    spy_state_t    state_q, state_d;
    logic [AW-1:0] wr_ptr_q, base_q, post_cnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RECORD:  if (trig) state_d = ST_CAPTURE;
            ST_CAPTURE: if (post_cnt_q == POST_LAST) state_d = ST_FROZEN;
            ST_FROZEN:  if (trig) state_d = ST_RECORD;
            default:    state_d = ST_RECORD;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_RECORD;
            wr_ptr_q   <= '0;
            base_q     <= '0;
            post_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (we) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (state_q == ST_RECORD && trig) begin
                base_q     <= wr_ptr_q - PRE_OFS;
                post_cnt_q <= AW'(1);
            end else if (state_q == ST_CAPTURE) begin
                post_cnt_q <= post_cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        we   = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_RECORD:  we = 1'b1;
            ST_CAPTURE: begin we = 1'b1; busy = 1'b1; end
            ST_FROZEN:  done = 1'b1;
            default:    we = 1'b0;
        endcase
    end

    assign wr_ptr   = wr_ptr_q;
    assign base_ptr = base_q;
endmodule

// File: rtl/spy_capture_buffer.sv
module spy_capture_buffer #(
    parameter int DATA_W      = 14,
    parameter int DEPTH       = 4096,
    parameter int PRE         = 64,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              ext_trig_in,
    input  logic              sw_trig,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              cap_busy,
    output logic              cap_done
);
    logic          trig_any, ext_rise, wr_en;
    logic [AW-1:0] wr_ptr, base_ptr, mem_raddr;

    spy_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_trig_in),
        .sw_in    (sw_trig),
        .ext_rise (ext_rise),
        .trig     (trig_any)
    );

    spy_capture_fsm #(.DEPTH(DEPTH), .PRE(PRE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig_any),
        .we       (wr_en),
        .wr_ptr   (wr_ptr),
        .base_ptr (base_ptr),
        .busy     (cap_busy),
        .done     (cap_done)
    );

    assign mem_raddr = base_ptr + rd_addr;

    spy_ring_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (smp_data),
        .raddr (mem_raddr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/spy_capture_checker.sv
module spy_capture_checker #(
    parameter int DEPTH = 4096,
    parameter int PRE   = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int POST = DEPTH - PRE
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trig,
    input logic          ext_rise,
    input logic          cap_busy,
    input logic          cap_done,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] base_ptr
);
    int unsigned busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n)        busy_len <= 0;
        else if (cap_busy) busy_len <= busy_len + 1;
        else               busy_len <= 0;
    end

    AST_CAPTURE_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_busy) |-> $past(trig)); // R3
    AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise); // R4
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_busy && cap_done)); // R6
    AST_WINDOW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_done) |-> busy_len == POST - 1); // R6
    AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cap_busy |=> $stable(base_ptr)); // R7
    AST_FROZEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> $stable(wr_ptr)); // R8
    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done && trig |=> !cap_done && !cap_busy); // R9
endmodule

bind spy_capture_buffer spy_capture_checker #(.DEPTH(DEPTH), .PRE(PRE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig_any),
    .ext_rise (ext_rise),
    .cap_busy (cap_busy),
    .cap_done (cap_done),
    .wr_ptr   (wr_ptr),
    .base_ptr (base_ptr)
);

// File: tb/sim_spy_capture_buffer.sv
module sim_spy_capture_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;
    localparam int PRE   = 4;
    localparam int POST  = DEPTH - PRE;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_trig = 1'b0;
    logic          ext_in = 1'b0;
    logic [7:0]    dcnt = 8'd0;
    logic [7:0]    smp8 = 8'd0;
    logic [31:0]   smp32 = 32'd0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd8;
    logic [31:0]   rd32;
    logic          busy0, done0, busy1, done1;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] wide(input logic [7:0] v);
        return {v, ~v, v ^ 8'h5A, v};
    endfunction

    spy_capture_buffer #(.DATA_W(8), .DEPTH(DEPTH), .PRE(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_data(smp8), .ext_trig_in(ext_in),
        .sw_trig(sw_trig), .rd_addr(rd_addr), .rd_data(rd8),
        .cap_busy(busy0), .cap_done(done0));

    spy_capture_buffer #(.DATA_W(32), .DEPTH(DEPTH), .PRE(PRE)) u1 (
        .clk(clk), .rst_n(rst_n), .smp_data(smp32), .ext_trig_in(ext_in),
        .sw_trig(sw_trig), .rd_addr(rd_addr), .rd_data(rd32),
        .cap_busy(busy1), .cap_done(done1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic flags(input string tag, input logic b, input logic d);
        chk({tag, " busy u0"}, {31'd0, busy0}, {31'd0, b});
        chk({tag, " done u0"}, {31'd0, done0}, {31'd0, d});
        chk({tag, " busy u1 (R10)"}, {31'd0, busy1}, {31'd0, b});
        chk({tag, " done u1 (R10)"}, {31'd0, done1}, {31'd0, d});
    endtask

    // one clock: drive at the falling edge, the next rising edge consumes it
    task automatic tick(input logic sw, input logic ext);
        @(negedge clk);
        dcnt    = dcnt + 8'd1;
        smp8    = dcnt;
        smp32   = wide(dcnt);
        sw_trig = sw;
        ext_in  = ext;
    endtask

    // after the trigger edge: run to completion, checking R6 timing
    task automatic capture_tail(input bit hold_ext, input bit noise, input string tag);
        for (int j = 1; j <= POST - 1; j++) begin
            if (noise && j == 5)      tick(1'b0, 1'b1);
            else if (noise && j == 6) tick(1'b1, 1'b0);
            else                      tick(1'b0, hold_ext);
            if (j == 1) flags({tag, " R6 busy after trigger"}, 1'b1, 1'b0);
        end
        flags({tag, " R6/R7 still capturing"}, 1'b1, 1'b0);
        tick(1'b0, hold_ext);
        flags({tag, " R6 done"}, 1'b0, 1'b1);
    endtask

    // read the whole window back; the stream keeps running (R8)
    task automatic verify_window(input logic [7:0] tv, input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] e;
            e = tv - 8'(PRE) + 8'(i);
            rd_addr = AW'(i);
            tick(1'b0, ext_in);
            chk({tag, " R5/R8 u0 window"}, {24'd0, rd8}, {24'd0, e});
            chk({tag, " R10 u1 window"}, rd32, wide(e));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] tv;
        repeat (3) tick(1'b0, 1'b0);
        flags("R1 reset", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (PRE + 6) tick(1'b0, 1'b0);
        flags("R1 idle after reset", 1'b0, 1'b0);

        // software triggers at stepping ring phases (R2, R3, R5, R9)
        for (int k = 0; k < 8; k++) begin
            repeat (PRE + 3 * k + 1) tick(1'b0, 1'b0);
            tick(1'b1, 1'b0);
            tv = dcnt;
            capture_tail(1'b0, (k % 2) == 1, "R3 sw");
            repeat (7) tick(1'b0, 1'b0);
            flags("R8 frozen holds", 1'b0, 1'b1);
            verify_window(tv, "R3 sw");
            tick(1'b1, 1'b0);
            tick(1'b0, 1'b0);
            flags("R9 rearm", 1'b0, 1'b0);
            repeat (DEPTH + 5) tick(1'b0, 1'b0);
            flags("R9 no capture after rearm", 1'b0, 1'b0);
        end

        // external trigger held high for a long time (R4)
        tick(1'b0, 1'b1);
        tv = dcnt + 8'd2;
        tick(1'b0, 1'b1);
        flags("R4 not yet", 1'b0, 1'b0);
        tick(1'b0, 1'b1);
        capture_tail(1'b1, 1'b0, "R4 ext");
        repeat (10) tick(1'b0, 1'b1);
        flags("R4 held input gives one trigger", 1'b0, 1'b1);
        verify_window(tv, "R4 ext");
        ext_in = 1'b0;

        // external pulse re-arms, a second pulse captures again (R9, R4)
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        flags("R9 ext rearm", 1'b0, 1'b0);
        repeat (PRE + 9) tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        tv = dcnt + 8'd2;
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        capture_tail(1'b0, 1'b1, "R4/R7 ext pulse");
        verify_window(tv, "R4/R7 ext pulse");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule